// File: doc/BRIEF.md
# Branch, Interrupt Entry and Prefetch Front End

This block sits at the fetch end of a 32-bit processor core that runs two instruction sets: a compact one with 16-bit instructions and a full one with 32-bit instructions. It owns the program counter, the status word, the link register and the saved status word used on interrupt entry. It also keeps a two-entry prefetch queue that it fills through a simple fetch port. Decode, execution, wait states and banked register storage are outside it.

A redirect happens on reset, on a jump request and on interrupt entry. Bit 0 of the target picks the instruction set. The block aligns the target and points the program counter one instruction past it. It then fetches two instructions, the first at the target and the second one instruction later. The core consumes instructions one at a time by pulsing `step`. Each step shifts the queue forward by one entry and fetches one new instruction at the updated program counter.

Interrupts are taken only at instruction boundaries and only while the mask bit is clear. A halt state waits for an interrupt request. When it wakes, it either takes the interrupt or resumes with the queue as it was.

Top module: `branch_prefetch_ctrl`

## Requirements
- R1: While `rst` is high, and after it falls, `status` is 0x000000D3, `link` and `irq_saved_sr` are 0, and `pc` is EXC_BASE+4. A 32-bit refill (`fetch_wide`=1) then starts at address EXC_BASE. EXC_BASE is 0x00000000 or 0xFFFF0000, with 0xFFFF0000 as the default.
- R2: For a jump whose effective target has bit 0 = 1, bit 0 of the target is cleared and `status` bit 5 (T) is set. `pc` becomes target+2. Two 16-bit fetches (`fetch_wide`=0) follow, at the target and at target+2. Each fetched word is stored zero-extended from `fetch_data[15:0]`.
- R3: For a jump whose effective target has bit 0 = 0, bits 1:0 of the target are cleared and T is cleared. `pc` becomes target+4. Two 32-bit fetches follow, at the target and at target+4.
- R4: When `jump_restore` is 1, `status` takes the value of `saved_sr`. The effective target bit 0 is replaced by `saved_sr` bit 5 before R2 or R3 applies.
- R5: An accepted `step` adds 2 (T=1) or 4 (T=0) to `pc`. The queue moves forward so that `instr` shows the instruction that was second in the queue. One fetch at the new `pc` then refills the second entry.
- R6: `instr_valid` is 1 only when both queue entries are filled. A fetch completes in a cycle where `fetch_req` and `fetch_ready` are both 1. After a redirect, `instr_valid` rises two cycles after the first cycle in which `fetch_ready` is held high. While `fetch_ready` is low, `fetch_addr` and `pc` hold.
- R7: A `jump_req` wins over a `step` and an `irq_req` that arrive in the same cycle. The block then goes only to the jump target, and `link` is unchanged.
- R8: While `status` bit 7 (I) is 1, `irq_req` has no effect. `link` and `irq_saved_sr` keep their values, and a `step` in the same cycle proceeds normally.
- R9: On interrupt entry, `irq_saved_sr` takes the old `status`. The low byte of `status` becomes 0xD2 and the upper 24 bits are kept. `link` becomes `pc`+2 if the old T was 1, or `pc` if it was 0. The block then jumps to EXC_BASE+0x18 (`pc` = EXC_BASE+0x1C, 32-bit state).
- R10: `irq_req` is sampled only when `instr_valid` is 1. A request held high during a refill is taken on the first clock edge after `instr_valid` rises.
- R11: A `halt_req` at an instruction boundary sets `halted`. While halted, `jump_req` and `step` are ignored, and `pc` and `link` hold until `irq_req` is 1.
- R12: If `irq_master_en` is 0 or I is 1 when `irq_req` wakes the halt, the block returns to running with `pc`, `link` and `instr` unchanged and `instr_valid` = 1. If `irq_master_en` is 1 and I is 0, it performs interrupt entry as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| jump_req | input | 1 | One-cycle jump request |
| jump_addr | input | 32 | Jump target address |
| jump_restore | input | 1 | Load status from saved_sr with this jump |
| saved_sr | input | 32 | Saved status word of the current mode |
| step | input | 1 | Consume one instruction |
| irq_req | input | 1 | Interrupt request level |
| halt_req | input | 1 | Enter halt at the next boundary |
| irq_master_en | input | 1 | Master interrupt enable used on halt wake |
| fetch_req | output | 1 | Fetch request valid |
| fetch_addr | output | 32 | Fetch address |
| fetch_wide | output | 1 | 1 = 32-bit fetch, 0 = 16-bit fetch |
| fetch_ready | input | 1 | Fetch accepted, data valid this cycle |
| fetch_data | input | 32 | Fetched data |
| pc | output | 32 | Program counter |
| status | output | 32 | Status word (bit 5 T, bit 7 I) |
| irq_saved_sr | output | 32 | Status saved on interrupt entry |
| link | output | 32 | Link register |
| instr | output | 32 | Oldest queued instruction |
| instr_valid | output | 1 | Queue full, instr may be consumed |
| halted | output | 1 | Block is halted |

## Verification
The hardest cases involve an interrupt request that reaches the block when it cannot act on it. One such case is a request during a refill, which must wait for the boundary. Another is a request while halted with the master enable off, which must wake the block without entering the handler. The bench holds `fetch_ready` low to freeze a refill while `irq_req` is held high. It then releases the port and checks `link` on the exact edge where entry is due. The halt cases are reached by enabling interrupts through a restoring jump, then pulsing `halt_req`. The bench also tries jumps and steps that must be ignored before it applies the waking request.

// File: rtl/fe_pkg.sv
package fe_pkg;
  typedef enum logic [1:0] {
    ST_FILL0 = 2'd0,
    ST_FILL1 = 2'd1,
    ST_RUN   = 2'd2,
    ST_HALT  = 2'd3
  } fe_state_e;

  localparam int T_BIT = 5;
  localparam int I_BIT = 7;
endpackage

// File: rtl/fe_target.sv
// Resolves a redirect target into instruction set, aligned address and new PC.
module fe_target #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] raw_addr,
  input  logic          restore,
  input  logic          saved_t,
  output logic          thumb,
  output logic [DW-1:0] new_pc
);
  logic [DW-1:0] aligned;

  always_comb begin
    thumb   = restore ? saved_t : raw_addr[0];
    aligned = thumb ? {raw_addr[DW-1:1], 1'b0} : {raw_addr[DW-1:2], 2'b00};
    new_pc  = aligned + (thumb ? DW'(2) : DW'(4));
  end
endmodule

// File: rtl/fe_irq_entry.sv
// Computes the status word and return address for interrupt entry.
module fe_irq_entry #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] old_sr,
  input  logic [DW-1:0] cur_pc,
  output logic [DW-1:0] new_sr,
  output logic [DW-1:0] ret_addr
);
  import fe_pkg::*;

  always_comb begin
    new_sr   = {old_sr[DW-1:8], 8'hD2};
    ret_addr = cur_pc + (old_sr[T_BIT] ? DW'(2) : DW'(0));
  end
endmodule

// File: rtl/fe_queue.sv
// Two-entry prefetch queue; half-word fetches are zero-extended.
module fe_queue #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load0,
  input  logic          load1,
  input  logic          shift,
  input  logic          half,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] slot0,
  output logic [DW-1:0] slot1
);
  localparam int HW = DW / 2;

  logic [DW-1:0] fill_word;

  always_comb
    fill_word = half ? {{(DW-HW){1'b0}}, wdata[HW-1:0]} : wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot0 <= '0;
      slot1 <= '0;
    end else begin
      if (load0) slot0 <= fill_word;
      else if (shift) slot0 <= slot1;
      if (load1) slot1 <= fill_word;
    end
  end

  // R5: a step moves the second entry to the head
  a_r5_queue_shift: assert property (@(posedge clk) disable iff (rst)
    (shift && !load0) |=> slot0 == $past(slot1));
endmodule

// File: rtl/branch_prefetch_ctrl.sv
module branch_prefetch_ctrl
  import fe_pkg::*;
#(
  parameter int            DW       = 32,
  parameter logic [DW-1:0] EXC_BASE = 32'hFFFF_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          jump_req,
  input  logic [DW-1:0] jump_addr,
  input  logic          jump_restore,
  input  logic [DW-1:0] saved_sr,
  input  logic          step,
  input  logic          irq_req,
  input  logic          halt_req,
  input  logic          irq_master_en,
  output logic          fetch_req,
  output logic [DW-1:0] fetch_addr,
  output logic          fetch_wide,
  input  logic          fetch_ready,
  input  logic [DW-1:0] fetch_data,
  output logic [DW-1:0] pc,
  output logic [DW-1:0] status,
  output logic [DW-1:0] irq_saved_sr,
  output logic [DW-1:0] link,
  output logic [DW-1:0] instr,
  output logic          instr_valid,
  output logic          halted
);
  localparam logic [DW-1:0] RESET_PC = EXC_BASE + DW'(4);
  localparam logic [DW-1:0] IRQ_PC   = EXC_BASE + DW'(32'h1C);
  localparam logic [DW-1:0] RESET_SR = DW'(32'hD3);

  fe_state_e     state;
  logic [DW-1:0] sr_q, pc_q, link_q, spsr_q;
  logic [DW-1:0] step_sz, tgt_pc, irq_sr, irq_link, slot0, slot1;
  logic          tgt_thumb, running, jump_go, irq_go, wake_plain, halt_go, step_go;
  logic          irq_allowed, load0, load1;

  fe_target #(.DW(DW)) u_target (
    .raw_addr (jump_addr),
    .restore  (jump_restore),
    .saved_t  (saved_sr[T_BIT]),
    .thumb    (tgt_thumb),
    .new_pc   (tgt_pc)
  );

  fe_irq_entry #(.DW(DW)) u_irq (
    .old_sr   (sr_q),
    .cur_pc   (pc_q),
    .new_sr   (irq_sr),
    .ret_addr (irq_link)
  );

  fe_queue #(.DW(DW)) u_queue (
    .clk   (clk),
    .rst   (rst),
    .load0 (load0),
    .load1 (load1),
    .shift (step_go),
    .half  (sr_q[T_BIT]),
    .wdata (fetch_data),
    .slot0 (slot0),
    .slot1 (slot1)
  );

  always_comb begin
    step_sz     = sr_q[T_BIT] ? DW'(2) : DW'(4);
    running     = (state == ST_RUN);
    jump_go     = jump_req && (state != ST_HALT);
    irq_allowed = !sr_q[I_BIT];
    irq_go      = !jump_go && irq_req &&
                  ((running && irq_allowed) ||
                   ((state == ST_HALT) && irq_allowed && irq_master_en));
    wake_plain  = (state == ST_HALT) && irq_req && !(irq_allowed && irq_master_en);
    halt_go     = running && !jump_go && !irq_go && halt_req;
    step_go     = running && !jump_go && !irq_go && !halt_go && step;
    fetch_req   = (state == ST_FILL0) || (state == ST_FILL1);
    fetch_wide  = !sr_q[T_BIT];
    fetch_addr  = (state == ST_FILL0) ? (pc_q - step_sz) : pc_q;
    load0       = (state == ST_FILL0) && fetch_ready && !jump_go;
    load1       = (state == ST_FILL1) && fetch_ready && !jump_go;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FILL0;
      sr_q   <= RESET_SR;
      pc_q   <= RESET_PC;
      link_q <= '0;
      spsr_q <= '0;
    end else if (jump_go) begin
      if (jump_restore) sr_q <= saved_sr;
      else sr_q[T_BIT] <= tgt_thumb;
      pc_q  <= tgt_pc;
      state <= ST_FILL0;
    end else if (irq_go) begin
      spsr_q <= sr_q;
      sr_q   <= irq_sr;
      link_q <= irq_link;
      pc_q   <= IRQ_PC;
      state  <= ST_FILL0;
    end else if (halt_go) begin
      state <= ST_HALT;
    end else if (wake_plain) begin
      state <= ST_RUN;
    end else if (step_go) begin
      pc_q  <= pc_q + step_sz;
      state <= ST_FILL1;
    end else if (load0) begin
      state <= ST_FILL1;
    end else if (load1) begin
      state <= ST_RUN;
    end
  end

  assign pc           = pc_q;
  assign status       = sr_q;
  assign irq_saved_sr = spsr_q;
  assign link         = link_q;
  assign instr        = slot0;
  assign instr_valid  = running;
  assign halted       = (state == ST_HALT);

  // R2: compact-state fetches are half-word aligned
  a_r2_half_align: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !fetch_wide) |-> !fetch_addr[0]);

  // R3: full-state fetches are word aligned
  a_r3_word_align: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_wide) |-> (fetch_addr[1:0] == 2'b00));

  // R5: an accepted step advances the PC by one instruction
  a_r5_step_pc: assert property (@(posedge clk) disable iff (rst)
    step_go |=> pc_q == $past(pc_q) + ($past(sr_q[T_BIT]) ? DW'(2) : DW'(4)));

  // R8: a masked request touches neither link nor saved status
  a_r8_masked_irq: assert property (@(posedge clk) disable iff (rst)
    (running && irq_req && sr_q[I_BIT] && !jump_req)
      |=> ($stable(link_q) && $stable(spsr_q)));

  // R9: interrupt entry state
  a_r9_irq_entry: assert property (@(posedge clk) disable iff (rst)
    irq_go |=> (sr_q[7:0] == 8'hD2) && (spsr_q == $past(sr_q)) && (pc_q == IRQ_PC));

  // R11: halt holds until an interrupt request
  a_r11_halt_hold: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_HALT) && !irq_req) |=> ((state == ST_HALT) && $stable(pc_q)));
endmodule

// File: tb/branch_prefetch_ctrl_tb.sv
module branch_prefetch_ctrl_tb;
  localparam logic [31:0] BASE   = 32'hFFFF_0000;
  localparam logic [31:0] IRQ_PC = BASE + 32'h1C;
  localparam int NV = 6;

  // jump vectors: target, restore, saved status, expected pc, expected T
  localparam logic [31:0] V_TGT [NV] = '{32'h1000, 32'h2001, 32'h3003, 32'h4006, 32'h5000, 32'h6003};
  localparam logic        V_RS  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [31:0] V_SSR [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h30, 32'h10};
  localparam logic [31:0] V_PC  [NV] = '{32'h1004, 32'h2002, 32'h3004, 32'h4008, 32'h5002, 32'h6004};
  localparam logic        V_T   [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

  logic clk = 1'b0, rst = 1'b1;
  logic jump_req = 0, jump_restore = 0, step = 0, irq_req = 0, halt_req = 0, irq_master_en = 0;
  logic [31:0] jump_addr = '0, saved_sr = '0;
  logic gnt = 1'b0;
  logic fetch_req, fetch_wide, instr_valid, halted;
  logic [31:0] fetch_addr, fetch_data, pc, status, irq_saved_sr, link, instr;
  int tests = 0, fails = 0;
  logic [31:0] keep_link, keep_spsr;

  always #10 clk = ~clk;

  assign fetch_data = {~fetch_addr[15:0], fetch_addr[15:0]};

  branch_prefetch_ctrl #(.DW(32), .EXC_BASE(BASE)) u_dut (
    .clk(clk), .rst(rst), .jump_req(jump_req), .jump_addr(jump_addr),
    .jump_restore(jump_restore), .saved_sr(saved_sr), .step(step),
    .irq_req(irq_req), .halt_req(halt_req), .irq_master_en(irq_master_en),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_wide(fetch_wide),
    .fetch_ready(gnt), .fetch_data(fetch_data), .pc(pc), .status(status),
    .irq_saved_sr(irq_saved_sr), .link(link), .instr(instr),
    .instr_valid(instr_valid), .halted(halted)
  );

  function automatic logic [31:0] exp_word(input logic [31:0] a, input logic t);
    return t ? {16'h0, a[15:0]} : {~a[15:0], a[15:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_jump(input logic [31:0] tgt, input logic rs, input logic [31:0] ssr);
    jump_addr = tgt; jump_restore = rs; saved_sr = ssr; jump_req = 1'b1;
    @(negedge clk);
    jump_req = 1'b0; jump_restore = 1'b0;
  endtask

  task automatic wait_valid(input string tag);
    for (int i = 0; i < 50; i++) begin
      if (instr_valid) break;
      @(negedge clk);
    end
    chk({tag, " instr_valid"}, {31'b0, instr_valid}, 32'd1);
  endtask

  task automatic pulse_step();
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 status in reset", status, 32'hD3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 status", status, 32'hD3);
    chk("R1 link", link, 32'h0);
    chk("R1 saved", irq_saved_sr, 32'h0);
    chk("R1 pc", pc, BASE + 32'd4);
    chk("R1 fetch addr", fetch_addr, BASE);
    chk("R1 fetch wide", {31'b0, fetch_wide}, 32'd1);
    chk("R6 not valid while stalled", {31'b0, instr_valid}, 32'd0);
    gnt = 1'b1;
    @(negedge clk);
    chk("R6 one fetch done, not valid", {31'b0, instr_valid}, 32'd0);
    chk("R1 second fetch addr", fetch_addr, BASE + 32'd4);
    @(negedge clk);
    chk("R6 valid after two fetches", {31'b0, instr_valid}, 32'd1);
    chk("R1 first instr", instr, exp_word(BASE, 1'b0));

    // R2 R3 R4 R5: vector walk
    for (int v = 0; v < NV; v++) begin
      logic [31:0] sz, al;
      sz = V_T[v] ? 32'd2 : 32'd4;
      al = V_PC[v] - sz;
      do_jump(V_TGT[v], V_RS[v], V_SSR[v]);
      wait_valid("R2/R3 jump");
      chk(V_T[v] ? "R2 pc" : "R3 pc", pc, V_PC[v]);
      chk("R2/R3 T bit", {31'b0, status[5]}, {31'b0, V_T[v]});
      chk("R2/R3 head instr", instr, exp_word(al, V_T[v]));
      if (V_RS[v]) chk("R4 status restored", status, V_SSR[v]);
      pulse_step();
      wait_valid("R5 step1");
      chk("R5 pc after step", pc, V_PC[v] + sz);
      chk("R5 instr after step", instr, exp_word(al + sz, V_T[v]));
      pulse_step();
      wait_valid("R5 step2");
      chk("R5 instr after second step", instr, exp_word(al + 2 * sz, V_T[v]));
    end

    // R6 stalled refill
    gnt = 1'b0;
    do_jump(32'h9000, 1'b0, 32'h0);
    repeat (4) @(negedge clk);
    chk("R6 held not valid", {31'b0, instr_valid}, 32'd0);
    chk("R6 held fetch addr", fetch_addr, 32'h9000);
    chk("R6 held pc", pc, 32'h9004);
    gnt = 1'b1;
    @(negedge clk);
    chk("R6 mid refill", {31'b0, instr_valid}, 32'd0);
    @(negedge clk);
    chk("R6 refill latency", {31'b0, instr_valid}, 32'd1);
    chk("R6 instr", instr, exp_word(32'h9000, 1'b0));

    // R7 jump priority (I is clear here, status 0x10)
    keep_link = link;
    jump_addr = 32'hA000; jump_req = 1'b1; step = 1'b1; irq_req = 1'b1;
    @(negedge clk);
    jump_req = 1'b0; step = 1'b0; irq_req = 1'b0;
    chk("R7 pc goes to jump", pc, 32'hA004);
    chk("R7 link unchanged", link, keep_link);
    wait_valid("R7");
    chk("R7 instr", instr, exp_word(32'hA000, 1'b0));

    // R8 masked interrupt
    do_jump(32'hB000, 1'b1, 32'h80);
    wait_valid("R8");
    keep_link = link; keep_spsr = irq_saved_sr;
    irq_req = 1'b1; step = 1'b1;
    @(negedge clk);
    irq_req = 1'b0; step = 1'b0;
    chk("R8 step proceeds", pc, 32'hB008);
    chk("R8 link kept", link, keep_link);
    chk("R8 saved kept", irq_saved_sr, keep_spsr);
    chk("R8 status kept", status, 32'h80);

    // R9 entry from 32-bit state
    do_jump(32'h7000, 1'b1, 32'hA000_0010);
    wait_valid("R9a");
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    chk("R9 status", status, 32'hA000_00D2);
    chk("R9 saved status", irq_saved_sr, 32'hA000_0010);
    chk("R9 link 32-bit", link, 32'h7004);
    chk("R9 pc vector", pc, IRQ_PC);
    chk("R9 vector fetch", fetch_addr, BASE + 32'h18);
    wait_valid("R9a vector");
    chk("R9 vector instr", instr, exp_word(BASE + 32'h18, 1'b0));

    // R9 entry from 16-bit state
    do_jump(32'h8000, 1'b1, 32'h30);
    wait_valid("R9b");
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    chk("R9 link 16-bit", link, 32'h8004);
    chk("R9 saved status 16-bit", irq_saved_sr, 32'h30);
    chk("R9 status 16-bit", status, 32'hD2);
    wait_valid("R9b vector");

    // R10 request held during refill
    gnt = 1'b0;
    irq_req = 1'b1;
    do_jump(32'hC000, 1'b1, 32'h10);
    repeat (3) @(negedge clk);
    chk("R10 not taken in refill", link, 32'h8004);
    gnt = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 boundary reached", {31'b0, instr_valid}, 32'd1);
    chk("R10 not yet taken", link, 32'h8004);
    @(negedge clk);
    irq_req = 1'b0;
    chk("R10 taken at boundary", link, 32'hC004);
    chk("R10 pc vector", pc, IRQ_PC);
    wait_valid("R10");

    // R11 halt ignores jump and step
    do_jump(32'hD000, 1'b1, 32'h10);
    wait_valid("R11");
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    chk("R11 halted", {31'b0, halted}, 32'd1);
    jump_addr = 32'hE000; jump_req = 1'b1; step = 1'b1;
    @(negedge clk);
    jump_req = 1'b0; step = 1'b0;
    @(negedge clk);
    chk("R11 still halted", {31'b0, halted}, 32'd1);
    chk("R11 pc held", pc, 32'hD004);
    chk("R11 no fetch", {31'b0, fetch_req}, 32'd0);

    // R12 wake without entry
    irq_master_en = 1'b0; irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    chk("R12 awake", {31'b0, halted}, 32'd0);
    chk("R12 valid kept", {31'b0, instr_valid}, 32'd1);
    chk("R12 pc kept", pc, 32'hD004);
    chk("R12 link kept", link, 32'hC004);
    chk("R12 instr kept", instr, exp_word(32'hD000, 1'b0));

    // R12 wake with entry
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    chk("R12 halted again", {31'b0, halted}, 32'd1);
    irq_master_en = 1'b1; irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    chk("R12 entry link", link, 32'hD004);
    chk("R12 entry pc", pc, IRQ_PC);
    chk("R12 entry saved", irq_saved_sr, 32'h10);
    wait_valid("R12 vector");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule